// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Reader

This block drives a 64-word by 16-bit serial EEPROM over three output lines (serial clock, chip select, data toward the device) and one input line (data from the device). A single start pulse makes it fetch the whole array. Each word uses its own read command, and the words come in ascending address order. Each word is handed to the surrounding logic together with its index, marked by a one-cycle valid pulse.

While it reads, the block keeps a wrapping 16-bit sum of every word. When the last word has been read, it raises a one-cycle completion pulse and reports whether the sum equals a fixed signature constant. The device must pull its data line low after each command. If it does not, the block takes this to mean that no device is attached and stops with an error flag.

All serial timing is built from a phase length in system clock cycles. That length is computed from the clock frequency and the wanted phase time (about 2 µs on real hardware). With the defaults, the length is kept short.

Top module: `ser_eeprom_reader`

## Requirements
- R1: Each command holds 9 bits, sent most significant bit first: 1, then 1, then 0, then the 6-bit word address. The data-out line changes only while the serial clock is low.
- R2: After reset, and whenever no read is running, the serial clock, chip select and data-out lines are all low. Chip select is high during every command and data bit.
- R3: Every high phase of the serial clock lasts exactly PHASE_CYCLES system clock cycles.
- R4: After the ninth command bit the block samples data-in. A 1 there ends the run: error goes high, chip select drops, no further word is output and no completion pulse occurs.
- R5: For each word, 16 bits are clocked in and placed most significant bit first. Each bit is taken at the end of its clock high phase. The word appears on wordData with its index on wordAddr, marked by a wordValid pulse one cycle long.
- R6: Between two words chip select is low, and exactly one serial clock pulse is issued.
- R7: Words are read from address 0 to address 63 in ascending order, with one command per word.
- R8: csumOk is 1 exactly when the wrapping 16-bit sum of all 64 words equals 0x1234. It is valid when done pulses and holds until the next start.
- R9: done pulses for one cycle, only after word 63 has been read.
- R10: A start while a read is running has no effect. A start from idle clears error and csumOk.
- R11: During reset, wordValid, done, error and csumOk are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start pulse for a full array read |
| eeSclk | output | 1 | Serial clock to the EEPROM |
| eeCs | output | 1 | Chip select to the EEPROM, active high |
| eeDo | output | 1 | Serial data to the EEPROM |
| eeDi | input | 1 | Serial data from the EEPROM |
| wordData | output | 16 | Most recently read word |
| wordAddr | output | 6 | Index of the word on wordData |
| wordValid | output | 1 | One-cycle strobe for a new word |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Set when no device answered; cleared by the next start |
| csumOk | output | 1 | Checksum result, valid from the done pulse |

## Verification
A bit counter that is off by one moves every later bit. The device model then finds the wrong command at the very next ninth bit, and the word that follows shows up shifted, within about 50 phases. An address counter that skips or repeats a value appears at once as a mismatch between wordAddr and the address the model decoded. It also changes the checksum flag at done. A timer fault shows up as a wrong clock high-phase length on the first pulse. A fault in the abort path shows up as words or a done pulse following a run that should have stopped.

// File: rtl/eeprom_rd_pkg.sv
package eeprom_rd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD_LO,
    ST_CMD_HI,
    ST_ACK_WAIT,
    ST_DAT_LO,
    ST_DAT_HI,
    ST_END_LO,
    ST_END_HI
  } rdState_t;

  typedef struct packed {
    logic clear;
    logic loadCmd;
    logic shiftCmd;
    logic sampleBit;
    logic wordDone;
    logic nextWord;
    logic finish;
  } rdStrobes_t;

endpackage

// File: rtl/eeprom_rd_ctrl.sv
module eeprom_rd_ctrl
  import eeprom_rd_pkg::*;
#(
  parameter int PHASE_CYCLES = 4,
  parameter int CMD_BITS     = 9,
  parameter int WORD_BITS    = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       eeDi,
  input  logic       cmdMsb,
  input  logic       lastWord,
  output rdStrobes_t strobe,
  output logic       eeSclk,
  output logic       eeCs,
  output logic       eeDo,
  output logic       error
);

  localparam int TW      = $clog2(PHASE_CYCLES + 1);
  localparam int CNT_MAX = (CMD_BITS > WORD_BITS) ? CMD_BITS : WORD_BITS;
  localparam int CW      = $clog2(CNT_MAX + 1);
  localparam logic [TW-1:0] TICK_AT   = TW'(PHASE_CYCLES - 1);
  localparam logic [CW-1:0] CMD_LAST  = CW'(CMD_BITS - 1);
  localparam logic [CW-1:0] WORD_LAST = CW'(WORD_BITS - 1);

  rdState_t      state, nextState;
  logic [TW-1:0] timer;
  logic [CW-1:0] bitCnt;
  logic          tick;
  logic          sclkQ, csQ, doEnQ, errQ;

  assign tick = (timer == TICK_AT);

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE:     if (start) nextState = ST_CMD_LO;
      ST_CMD_LO:   if (tick) nextState = ST_CMD_HI;
      ST_CMD_HI:   if (tick) nextState = (bitCnt == CMD_LAST) ? ST_ACK_WAIT : ST_CMD_LO;
      ST_ACK_WAIT: if (tick) nextState = eeDi ? ST_IDLE : ST_DAT_LO;
      ST_DAT_LO:   if (tick) nextState = ST_DAT_HI;
      ST_DAT_HI:   if (tick) nextState = (bitCnt == WORD_LAST) ? ST_END_LO : ST_DAT_LO;
      ST_END_LO:   if (tick) nextState = ST_END_HI;
      ST_END_HI:   if (tick) nextState = lastWord ? ST_IDLE : ST_CMD_LO;
      default:     nextState = ST_IDLE;
    endcase
  end

  always_comb begin
    strobe = '0;
    unique case (state)
      ST_IDLE: begin
        strobe.clear   = start;
        strobe.loadCmd = start;
      end
      ST_CMD_HI: strobe.shiftCmd = tick && (bitCnt != CMD_LAST);
      ST_DAT_HI: begin
        strobe.sampleBit = tick;
        strobe.wordDone  = tick && (bitCnt == WORD_LAST);
      end
      ST_END_HI: begin
        strobe.finish   = tick && lastWord;
        strobe.nextWord = tick && !lastWord;
        strobe.loadCmd  = tick && !lastWord;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      timer  <= '0;
      bitCnt <= '0;
      errQ   <= 1'b0;
      sclkQ  <= 1'b0;
      csQ    <= 1'b0;
      doEnQ  <= 1'b0;
    end else begin
      state <= nextState;
      if (state == ST_IDLE || tick) timer <= '0;
      else                          timer <= timer + 1'b1;

      if (state == ST_IDLE)
        bitCnt <= '0;
      else if (tick && state == ST_CMD_HI)
        bitCnt <= (bitCnt == CMD_LAST) ? '0 : bitCnt + 1'b1;
      else if (tick && state == ST_DAT_HI)
        bitCnt <= (bitCnt == WORD_LAST) ? '0 : bitCnt + 1'b1;

      if (state == ST_IDLE && start)                    errQ <= 1'b0;
      else if (state == ST_ACK_WAIT && tick && eeDi)    errQ <= 1'b1;

      sclkQ <= (nextState == ST_CMD_HI) || (nextState == ST_DAT_HI) ||
               (nextState == ST_END_HI);
      csQ   <= (nextState == ST_CMD_LO) || (nextState == ST_CMD_HI) ||
               (nextState == ST_ACK_WAIT) || (nextState == ST_DAT_LO) ||
               (nextState == ST_DAT_HI);
      doEnQ <= (nextState == ST_CMD_LO) || (nextState == ST_CMD_HI);
    end
  end

  assign eeSclk = sclkQ;
  assign eeCs   = csQ;
  assign eeDo   = doEnQ & cmdMsb;
  assign error  = errQ;

  // R1: data toward the device never moves while the serial clock is high
  a_r1_do_steady: assert property (@(posedge clk) disable iff (!rstN)
    eeSclk |-> $stable(eeDo));

  // R4: a high dummy bit aborts with the flag set and the device deselected
  a_r4_abort: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ACK_WAIT && tick && eeDi) |=> (error && !eeCs && state == ST_IDLE));

  // R6: the gap pulse between words happens with chip select low
  a_r6_gap_deselect: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_END_HI) |-> (!eeCs && eeSclk));

  // R10: a start during a running read does not leave the running state
  a_r10_busy_start: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE && !tick && start) |=> (state != ST_IDLE));

  // R2: idle means all serial lines low
  a_r2_idle_lines: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && $past(state) == ST_IDLE) |-> (!eeSclk && !eeCs && !eeDo));

endmodule

// File: rtl/eeprom_rd_dp.sv
module eeprom_rd_dp
  import eeprom_rd_pkg::*;
#(
  parameter int          ADDR_BITS   = 6,
  parameter int          WORD_BITS   = 16,
  parameter logic [15:0] CSUM_TARGET = 16'h1234
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  rdStrobes_t           strobe,
  input  logic                 eeDi,
  output logic                 cmdMsb,
  output logic                 lastWord,
  output logic [WORD_BITS-1:0] wordData,
  output logic [ADDR_BITS-1:0] wordAddr,
  output logic                 wordValid,
  output logic                 done,
  output logic                 csumOk
);

  localparam int CMD_BITS = ADDR_BITS + 3;
  localparam logic [2:0]           READ_HDR  = 3'b110;
  localparam logic [ADDR_BITS-1:0] LAST_ADDR = '1;

  logic [CMD_BITS-1:0]  cmdSh;
  logic [WORD_BITS-1:0] dataSh;
  logic [WORD_BITS-1:0] assembled;
  logic [WORD_BITS-1:0] sum;
  logic [ADDR_BITS-1:0] addr;
  logic [ADDR_BITS-1:0] cmdAddr;

  assign assembled = {dataSh[WORD_BITS-2:0], eeDi};
  assign cmdAddr   = strobe.clear ? {ADDR_BITS{1'b0}} : addr + 1'b1;
  assign cmdMsb    = cmdSh[CMD_BITS-1];
  assign lastWord  = (addr == LAST_ADDR);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdSh     <= '0;
      dataSh    <= '0;
      sum       <= '0;
      addr      <= '0;
      wordData  <= '0;
      wordAddr  <= '0;
      wordValid <= 1'b0;
      done      <= 1'b0;
      csumOk    <= 1'b0;
    end else begin
      wordValid <= 1'b0;
      done      <= 1'b0;

      if (strobe.clear) begin
        addr   <= '0;
        sum    <= '0;
        csumOk <= 1'b0;
      end

      if (strobe.loadCmd)       cmdSh <= {READ_HDR, cmdAddr};
      else if (strobe.shiftCmd) cmdSh <= {cmdSh[CMD_BITS-2:0], 1'b0};

      if (strobe.sampleBit) dataSh <= assembled;

      if (strobe.wordDone) begin
        wordData  <= assembled;
        wordAddr  <= addr;
        wordValid <= 1'b1;
        sum       <= sum + assembled;
      end

      if (strobe.nextWord) addr <= addr + 1'b1;

      if (strobe.finish) begin
        done   <= 1'b1;
        csumOk <= (sum == CSUM_TARGET[WORD_BITS-1:0]);
      end
    end
  end

  // R7: the word index advances by exactly one per word
  a_r7_addr_step: assert property (@(posedge clk) disable iff (!rstN)
    strobe.nextWord |=> (addr == ADDR_BITS'($past(addr) + 1'b1)));

  // R5: the word strobe lasts a single cycle
  a_r5_valid_pulse: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |=> !wordValid);

  // R9: completion only with the final index and as a single-cycle pulse
  a_r9_done_last: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (lastWord && wordAddr == LAST_ADDR && !wordValid));

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8: the checksum flag stays put between completion and the next start
  a_r8_csum_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.clear && !strobe.finish) |=> $stable(csumOk));

endmodule

// File: rtl/ser_eeprom_reader.sv
module ser_eeprom_reader
  import eeprom_rd_pkg::*;
#(
  parameter int          CLK_MHZ     = 2,
  parameter int          PHASE_US    = 2,
  parameter int          ADDR_BITS   = 6,
  parameter int          WORD_BITS   = 16,
  parameter logic [15:0] CSUM_TARGET = 16'h1234
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  output logic                 eeSclk,
  output logic                 eeCs,
  output logic                 eeDo,
  input  logic                 eeDi,
  output logic [WORD_BITS-1:0] wordData,
  output logic [ADDR_BITS-1:0] wordAddr,
  output logic                 wordValid,
  output logic                 done,
  output logic                 error,
  output logic                 csumOk
);

  localparam int PHASE_CYCLES = (CLK_MHZ * PHASE_US < 1) ? 1 : CLK_MHZ * PHASE_US;
  localparam int CMD_BITS     = ADDR_BITS + 3;

  rdStrobes_t strobe;
  logic       cmdMsb;
  logic       lastWord;

  eeprom_rd_ctrl #(
    .PHASE_CYCLES(PHASE_CYCLES),
    .CMD_BITS    (CMD_BITS),
    .WORD_BITS   (WORD_BITS)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .eeDi    (eeDi),
    .cmdMsb  (cmdMsb),
    .lastWord(lastWord),
    .strobe  (strobe),
    .eeSclk  (eeSclk),
    .eeCs    (eeCs),
    .eeDo    (eeDo),
    .error   (error)
  );

  eeprom_rd_dp #(
    .ADDR_BITS  (ADDR_BITS),
    .WORD_BITS  (WORD_BITS),
    .CSUM_TARGET(CSUM_TARGET)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .eeDi     (eeDi),
    .cmdMsb   (cmdMsb),
    .lastWord (lastWord),
    .wordData (wordData),
    .wordAddr (wordAddr),
    .wordValid(wordValid),
    .done     (done),
    .csumOk   (csumOk)
  );

  // R11: quiet outputs while reset is held
  always_comb begin
    if (!rstN) begin
      a_r11_reset_quiet: assert (!wordValid && !done && !error && !csumOk);
    end
  end

endmodule

// File: tb/ser_eeprom_reader_test.sv
`timescale 1ns/1ps
module ser_eeprom_reader_test;

  localparam int PH = 4;  // 2 MHz * 2 us

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        eeSclk, eeCs, eeDo;
  logic        devDi = 1'b1;
  logic [15:0] wordData;
  logic [5:0]  wordAddr;
  logic        wordValid, done, error, csumOk;

  always #2 clk = ~clk;

  ser_eeprom_reader uut (
    .clk(clk), .rstN(rstN), .start(start),
    .eeSclk(eeSclk), .eeCs(eeCs), .eeDo(eeDo), .eeDi(devDi),
    .wordData(wordData), .wordAddr(wordAddr), .wordValid(wordValid),
    .done(done), .error(error), .csumOk(csumOk)
  );

  int checks = 0;
  int errors = 0;

  // device model
  logic [15:0] mem [64];
  bit          present = 1'b1;
  int          bitPos = 0;
  logic [8:0]  cmdSh = '0;
  logic [5:0]  curAddr = '0;
  int          expAddr = 0;
  int          cmdErrs = 0;
  int          gapPulses = 0;

  always @(posedge eeSclk or negedge eeCs) begin
    if (!eeCs) begin
      if (eeSclk) gapPulses++;
      bitPos = 0;
    end else begin
      bitPos++;
      if (bitPos <= 9) cmdSh = {cmdSh[7:0], eeDo};
      if (bitPos == 9) begin
        if (cmdSh != {3'b110, 6'(expAddr)}) cmdErrs++;
        curAddr = cmdSh[5:0];
        expAddr++;
        devDi <= present ? 1'b0 : 1'b1;
      end else if (bitPos >= 10 && bitPos <= 25) begin
        devDi <= present ? mem[curAddr][25 - bitPos] : 1'b1;
      end
    end
  end

  // output monitor
  logic [15:0] capData [64];
  logic [5:0]  capAddr [64];
  int wordCnt = 0, doneCnt = 0, csumAtDone = -1, errRise = 0;
  int hiRun = 0, hiBad = 0, hiSeen = 0;
  bit prevErr = 1'b0;

  always @(negedge clk) begin
    if (wordValid) begin
      if (wordCnt < 64) begin
        capData[wordCnt] = wordData;
        capAddr[wordCnt] = wordAddr;
      end
      wordCnt++;
    end
    if (done) begin
      doneCnt++;
      csumAtDone = int'(csumOk);
    end
    if (error && !prevErr) errRise++;
    prevErr = error;
    if (eeSclk) hiRun++;
    else if (hiRun != 0) begin
      hiSeen++;
      if (hiRun != PH) hiBad++;
      hiRun = 0;
    end
  end

  task automatic checkEq(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clearMon();
    wordCnt = 0; doneCnt = 0; csumAtDone = -1; errRise = 0;
    hiBad = 0; hiSeen = 0; expAddr = 0; cmdErrs = 0; gapPulses = 0;
  endtask

  task automatic pulseStart();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic waitEnd(int limit);
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (doneCnt > 0 || errRise > 0) break;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic fillImage(bit goodSum);
    logic [15:0] s = '0;
    for (int i = 0; i < 63; i++) begin
      mem[i] = 16'(i * 16'h0137 + 16'hA5C3) ^ 16'(i << 9);
      s = s + mem[i];
    end
    mem[63] = 16'h1234 - s;
    if (!goodSum) mem[17] = mem[17] ^ 16'h0040;
  endtask

  task automatic checkWords(string tag);
    int badD = 0, badA = 0;
    for (int i = 0; i < 64; i++) begin
      if (capData[i] != mem[i]) badD++;
      if (capAddr[i] != 6'(i)) badA++;
    end
    checkEq("R5", {tag, " word data mismatches"}, badD, 0);
    checkEq("R7", {tag, " word index mismatches"}, badA, 0);
  endtask

  task automatic testReset();
    checkEq("R11", "wordValid in reset", int'(wordValid), 0);
    checkEq("R11", "done in reset", int'(done), 0);
    checkEq("R11", "error in reset", int'(error), 0);
    checkEq("R11", "csumOk in reset", int'(csumOk), 0);
    checkEq("R2", "lines in reset", int'({eeSclk, eeCs, eeDo}), 0);
  endtask

  task automatic testGoodImage();
    fillImage(1'b1);
    present = 1'b1;
    clearMon();
    pulseStart();
    waitEnd(20000);
    checkEq("R7", "words received", wordCnt, 64);
    checkWords("good");
    checkEq("R1", "bad commands seen by device", cmdErrs, 0);
    checkEq("R7", "commands issued", expAddr, 64);
    checkEq("R6", "gap pulses", gapPulses, 64);
    checkEq("R3", "high phases of wrong length", hiBad, 0);
    checkEq("R3", "high phases seen", hiSeen, 64 * 26);
    checkEq("R9", "done pulses", doneCnt, 1);
    checkEq("R8", "csumOk at done", csumAtDone, 1);
    checkEq("R8", "csumOk held", int'(csumOk), 1);
    checkEq("R4", "error after good read", int'(error), 0);
    checkEq("R2", "lines idle after read", int'({eeSclk, eeCs, eeDo}), 0);
  endtask

  task automatic testBadSum();
    fillImage(1'b0);
    clearMon();
    pulseStart();
    @(negedge clk);
    checkEq("R10", "csumOk cleared by start", int'(csumOk), 0);
    waitEnd(20000);
    checkEq("R7", "words received bad image", wordCnt, 64);
    checkWords("bad");
    checkEq("R9", "done pulses bad image", doneCnt, 1);
    checkEq("R8", "csumOk with wrong sum", csumAtDone, 0);
  endtask

  task automatic testStartIgnored();
    fillImage(1'b1);
    clearMon();
    pulseStart();
    repeat (3001) @(negedge clk);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (1777) @(negedge clk);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    waitEnd(20000);
    checkEq("R10", "words with extra starts", wordCnt, 64);
    checkWords("busy");
    checkEq("R10", "commands with extra starts", expAddr, 64);
    checkEq("R10", "bad commands with extra starts", cmdErrs, 0);
    checkEq("R9", "done pulses with extra starts", doneCnt, 1);
  endtask

  task automatic testAbsent();
    present = 1'b0;
    devDi = 1'b1;
    clearMon();
    pulseStart();
    waitEnd(2000);
    checkEq("R4", "error on missing device", int'(error), 1);
    checkEq("R4", "words on missing device", wordCnt, 0);
    checkEq("R4", "done on missing device", doneCnt, 0);
    checkEq("R4", "chip select after abort", int'(eeCs), 0);
    checkEq("R4", "commands before abort", expAddr, 1);
    repeat (200) @(negedge clk);
    checkEq("R4", "no late words after abort", wordCnt, 0);
  endtask

  task automatic testRestart();
    present = 1'b1;
    fillImage(1'b1);
    clearMon();
    pulseStart();
    @(negedge clk);
    checkEq("R10", "error cleared by start", int'(error), 0);
    waitEnd(20000);
    checkEq("R7", "words after restart", wordCnt, 64);
    checkEq("R8", "csumOk after restart", csumAtDone, 1);
  endtask

  bit finished = 1'b0;

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testGoodImage();
    testBadSum();
    testStartIgnored();
    testAbsent();
    testRestart();
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog run did not complete actual %0d expected %0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule